// File: doc/BRIEF.md
# Miscellaneous Status Register with Atomic Update Aliases

This block holds one 64-bit status and control word on a word-addressed synchronous register bus. Software reaches the word through three neighbouring word offsets: a direct offset that loads or returns the value, and two alias offsets. The aliases change the stored value in a single bus write, so no read-modify-write is needed. A build-time parameter picks one of two address maps. In the legacy map the aliases AND and OR the value with the write data. In the newer map they clear it outright or OR data into it. Bits are numbered from the most significant end, and only the top nineteen bits of the word exist.

The top bit (bit 0) drives a level interrupt output. A request input from the rest of the unit posts a message by setting the interrupt bit and the shared-memory message bit together. Reads return data one cycle after the request, with a valid strobe. The response path is a two-state machine: RD_IDLE moves to RD_RESP when a read is accepted. RD_RESP stays in RD_RESP on a back-to-back read and returns to RD_IDLE otherwise. An access to any offset the selected map does not decode produces a one-cycle flag.

Top module: `misc_status_reg`

## Requirements
- R1: After reset the stored value is zero, `irq_o` is low and `rd_valid` is low.
- R2: Only bits 0 to 18, counted from the MSB (data[63:45]), are kept; data[44:0] read as zero after every kind of update.
- R3: A write to the direct offset (word 0x4020 in the legacy map, 0x6080 in the newer map) replaces the value, and a read of the direct offset returns it.
- R4: In the legacy map (MAP_SEL=0), a write to word 0x4021 ANDs the value with the write data and a write to word 0x4022 ORs the write data into it.
- R5: In the newer map (MAP_SEL=1), a write to word 0x6081 sets the value to zero whatever the write data, and a write to word 0x6082 ORs the write data into it.
- R6: `irq_o` is a level equal to bit 0 (data[63]) of the stored value, valid from the clock edge that stores the value.
- R7: A cycle with `raise_req` high ORs bit 0 (data[63]) and bit 3 (data[60]) into the value.
- R8: When a bus write and `raise_req` occur in the same cycle, the write result is formed first and the raise bits are then ORed on top.
- R9: The word offset is the byte address shifted right by three; address bits [2:0] are ignored.
- R10: A read produces `rd_valid` high for exactly the cycle after the request, with `rd_data` holding the value stored at the request. A read of any offset other than the direct one returns zero.
- R11: A read or write to an offset outside the three of the selected map leaves the value unchanged and raises `unimpl_pulse` for the one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of an 8-byte access |
| bus_wdata | input | 64 | Write data |
| raise_req | input | 1 | Post a message: set interrupt and message bits |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| irq_o | output | 1 | Level interrupt (bit 0 of the value) |
| unimpl_pulse | output | 1 | Access to an undecoded offset |

## Verification
Every result of this block falls due one clock edge after its stimulus. The stored value, and with it `irq_o`, changes at the edge that accepts a write or raise. `rd_valid`, `rd_data` and `unimpl_pulse` are registered at the edge that accepts the request. The bench drives each request on a falling edge and samples the outputs on the next falling edge, half a cycle after the edge that updates them. It drops the request only after that sample, so a single access is never counted twice. A further sample one cycle later confirms that the strobes have fallen again.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_AND,
        OP_OR,
        OP_ZERO
    } reg_op_t;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_t;

    // direct-offset word addresses of the two maps; aliases follow at +1, +2
    localparam int unsigned LEGACY_BASE = 32'h4020;
    localparam int unsigned NEWER_BASE  = 32'h6080;

endpackage

// File: rtl/misc_reg_decode.sv
module misc_reg_decode
    import misc_reg_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MAP_SEL = 0
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_op_t           wr_op,
    output logic              rd_direct,
    output logic              unimpl
);
    localparam int WORD_W = ADDR_W - 3;
    localparam int unsigned BASE = (MAP_SEL == 0) ? LEGACY_BASE : NEWER_BASE;
    localparam logic [WORD_W-1:0] OFF_DIRECT = WORD_W'(BASE);
    localparam logic [WORD_W-1:0] OFF_ALIAS1 = WORD_W'(BASE + 1);
    localparam logic [WORD_W-1:0] OFF_ALIAS2 = WORD_W'(BASE + 2);

    logic [WORD_W-1:0] word;
    logic [2:0]        unused_lsbs;
    reg_op_t           alias1_op;
    logic              hit_direct, hit_a1, hit_a2;

    assign word        = bus_addr[ADDR_W-1:3];
    assign unused_lsbs = bus_addr[2:0];

    generate
        if (MAP_SEL == 0) begin : g_legacy
            assign alias1_op = OP_AND;
        end else begin : g_newer
            assign alias1_op = OP_ZERO;
        end
    endgenerate

    assign hit_direct = (word == OFF_DIRECT);
    assign hit_a1     = (word == OFF_ALIAS1);
    assign hit_a2     = (word == OFF_ALIAS2);

    always_comb begin
        wr_op = OP_HOLD;
        if (bus_req && bus_we) begin
            if (hit_direct)  wr_op = OP_LOAD;
            else if (hit_a1) wr_op = alias1_op;
            else if (hit_a2) wr_op = OP_OR;
        end
    end

    assign rd_direct = bus_req && !bus_we && hit_direct;
    assign unimpl    = bus_req && !(hit_direct || hit_a1 || hit_a2);

endmodule

// File: rtl/misc_reg_core.sv
module misc_reg_core
    import misc_reg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int KEEP_BITS = 19,
    parameter int IRQ_POS   = 0,
    parameter int MSG_POS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_op_t           wr_op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              raise_req,
    output logic [DATA_W-1:0] value
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{KEEP_BITS{1'b1}}, {(DATA_W-KEEP_BITS){1'b0}}};
    localparam logic [DATA_W-1:0] RAISE_BITS =
        (DATA_W'(1) << (DATA_W-1-IRQ_POS)) | (DATA_W'(1) << (DATA_W-1-MSG_POS));

    logic [DATA_W-1:0] after_bus, after_raise;

    always_comb begin
        unique case (wr_op)
            OP_LOAD: after_bus = wdata;
            OP_AND:  after_bus = value & wdata;
            OP_OR:   after_bus = value | wdata;
            OP_ZERO: after_bus = '0;
            default: after_bus = value;
        endcase
        after_raise = raise_req ? (after_bus | RAISE_BITS) : after_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= after_raise & KEEP_MASK;
    end

endmodule

// File: rtl/misc_reg_rdport.sv
module misc_reg_rdport
    import misc_reg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_direct,
    input  logic              unimpl,
    input  logic [DATA_W-1:0] value,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              unimpl_pulse
);
    rd_state_t state, state_nx;

    always_comb begin
        unique case (state)
            RD_IDLE: state_nx = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_nx = rd_req ? RD_RESP : RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            unimpl_pulse <= 1'b0;
        end else begin
            unimpl_pulse <= unimpl;
            if (rd_req) rd_data <= rd_direct ? value : '0;
        end
    end

    always_comb begin
        rd_valid = (state == RD_RESP);
    end

endmodule

// File: rtl/misc_status_reg.sv
module misc_status_reg
    import misc_reg_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MAP_SEL   = 0,
    parameter int KEEP_BITS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic              raise_req,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              irq_o,
    output logic              unimpl_pulse
);
    localparam int DATA_W = 64;

    reg_op_t           wr_op;
    logic              rd_direct, unimpl;
    logic [DATA_W-1:0] value;

    misc_reg_decode #(.ADDR_W(ADDR_W), .MAP_SEL(MAP_SEL)) u_dec (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wr_op     (wr_op),
        .rd_direct (rd_direct),
        .unimpl    (unimpl)
    );

    misc_reg_core #(.DATA_W(DATA_W), .KEEP_BITS(KEEP_BITS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_op     (wr_op),
        .wdata     (bus_wdata),
        .raise_req (raise_req),
        .value     (value)
    );

    misc_reg_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (bus_req && !bus_we),
        .rd_direct    (rd_direct),
        .unimpl       (unimpl),
        .value        (value),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .unimpl_pulse (unimpl_pulse)
    );

    assign irq_o = value[DATA_W-1];

endmodule

// File: rtl/misc_status_reg_chk.sv
module misc_status_reg_chk #(
    parameter int ADDR_W    = 20,
    parameter int MAP_SEL   = 0,
    parameter int KEEP_BITS = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic              raise_req,
    input logic              rd_valid,
    input logic [63:0]       rd_data,
    input logic              irq_o,
    input logic              unimpl_pulse
);
    localparam logic [63:0] DROP = {{KEEP_BITS{1'b0}}, {(64-KEEP_BITS){1'b1}}};
    localparam logic [ADDR_W-4:0] W_OR =
        (MAP_SEL == 0) ? (ADDR_W-3)'(32'h4022) : (ADDR_W-3)'(32'h6082);

    p_kept_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & DROP) == 64'd0));

    p_irq_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_data != 64'd0) |-> (rd_data[63] == $past(irq_o)));

    p_raise_sets_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        raise_req |=> irq_o);

    p_or_alias_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[ADDR_W-1:3] == W_OR && bus_wdata[63]) |=> irq_o);

    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !rd_valid);

    p_unimpl_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_pulse |-> $past(bus_req));

    generate
        if (MAP_SEL != 0) begin : g_newer_chk
            localparam logic [ADDR_W-4:0] W_CLR = (ADDR_W-3)'(32'h6081);
            p_clear_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_req && bus_we && bus_addr[ADDR_W-1:3] == W_CLR && !raise_req) |=> !irq_o);
        end
    endgenerate

endmodule

bind misc_status_reg misc_status_reg_chk #(
    .ADDR_W(ADDR_W), .MAP_SEL(MAP_SEL), .KEEP_BITS(KEEP_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .raise_req    (raise_req),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .irq_o        (irq_o),
    .unimpl_pulse (unimpl_pulse)
);

// File: tb/misc_status_reg_test.sv
module misc_status_reg_test;

    localparam int ADDR_W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, req_b = 1'b0;
    logic raise_a = 1'b0, raise_b = 1'b0;
    logic we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [63:0] wdata = '0;

    logic rv_a, irq_a, un_a, rv_b, irq_b, un_b;
    logic [63:0] rd_a, rd_b;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    misc_status_reg #(.ADDR_W(ADDR_W), .MAP_SEL(0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(req_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .raise_req(raise_a), .rd_valid(rv_a), .rd_data(rd_a),
        .irq_o(irq_a), .unimpl_pulse(un_a)
    );

    misc_status_reg #(.ADDR_W(ADDR_W), .MAP_SEL(1)) uut_v2 (
        .clk(clk), .rst_n(rst_n), .bus_req(req_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .raise_req(raise_b), .rd_valid(rv_b), .rd_data(rd_b),
        .irq_o(irq_b), .unimpl_pulse(un_b)
    );

    // byte addresses
    localparam logic [ADDR_W-1:0] A_DIR  = 20'h20100;
    localparam logic [ADDR_W-1:0] A_AND  = 20'h20108;
    localparam logic [ADDR_W-1:0] A_OR   = 20'h20110;
    localparam logic [ADDR_W-1:0] A_BAD  = 20'h20118;
    localparam logic [ADDR_W-1:0] B_DIR  = 20'h30400;
    localparam logic [ADDR_W-1:0] B_CLR  = 20'h30408;
    localparam logic [ADDR_W-1:0] B_OR   = 20'h30410;

    typedef struct packed {
        logic [ADDR_W-1:0] baddr;
        logic [63:0]       wdata;
        logic [63:0]       expv;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{A_DIR,      64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_E000_0000_0000},
        '{A_AND,      64'h0F0F_0000_0000_0000, 64'h0F0F_0000_0000_0000},
        '{A_OR,       64'h8000_1000_0000_0000, 64'h8F0F_0000_0000_0000},
        '{A_DIR,      64'h0000_2000_0000_0001, 64'h0000_2000_0000_0000},
        '{20'h20115,  64'h4000_0000_0000_0000, 64'h4000_2000_0000_0000},
        '{A_BAD,      64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_2000_0000_0000},
        '{B_DIR,      64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_2000_0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus access; outputs sampled on the falling edge after the accepting edge
    task automatic access(input bit dut_b, input bit is_wr, input logic [ADDR_W-1:0] a,
                          input logic [63:0] d, input bit with_raise,
                          output logic v, output logic [63:0] rd, output logic un);
        @(negedge clk);
        we = is_wr; addr = a; wdata = d;
        if (dut_b) begin req_b = 1'b1; raise_b = with_raise; end
        else       begin req_a = 1'b1; raise_a = with_raise; end
        @(negedge clk);
        v  = dut_b ? rv_b : rv_a;
        rd = dut_b ? rd_b : rd_a;
        un = dut_b ? un_b : un_a;
        req_a = 1'b0; req_b = 1'b0; raise_a = 1'b0; raise_b = 1'b0; we = 1'b0;
    endtask

    task automatic read_direct(input bit dut_b, output logic [63:0] rd);
        logic v, un;
        access(dut_b, 1'b0, dut_b ? B_DIR : A_DIR, 64'd0, 1'b0, v, rd, un);
        check("R10 read valid", {63'd0, v}, 64'd1);
    endtask

    initial begin
        logic v, un;
        logic [63:0] rd;

        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is still applied
        check("R1 rd_valid", {63'd0, rv_a}, 64'd0);
        check("R1 irq", {63'd0, irq_a}, 64'd0);
        rst_n = 1'b1;
        read_direct(1'b0, rd);
        check("R1 value a", rd, 64'd0);
        read_direct(1'b1, rd);
        check("R1 value b", rd, 64'd0);

        // table walk on the legacy map: R2 R3 R4 R9 R11 and irq level R6
        for (int i = 0; i < NVEC; i++) begin
            access(1'b0, 1'b1, VECS[i].baddr, VECS[i].wdata, 1'b0, v, rd, un);
            check("R6 irq level", {63'd0, irq_a}, {63'd0, VECS[i].expv[63]});
            check("R11 pulse on write", {63'd0, un},
                  {63'd0, (VECS[i].baddr == A_BAD || VECS[i].baddr == B_DIR)});
            read_direct(1'b0, rd);
            check("R2 R3 R4 R9 R11 value", rd, VECS[i].expv);
        end

        // R7: raise alone sets bits 0 and 3
        @(negedge clk); raise_a = 1'b1;
        @(negedge clk); raise_a = 1'b0;
        check("R7 irq after raise", {63'd0, irq_a}, 64'd1);
        read_direct(1'b0, rd);
        check("R7 value", rd, 64'hD000_2000_0000_0000);

        // R8: write and raise in the same cycle
        access(1'b0, 1'b1, A_DIR, 64'd0, 1'b1, v, rd, un);
        read_direct(1'b0, rd);
        check("R8 load then raise", rd, 64'h9000_0000_0000_0000);
        access(1'b0, 1'b1, A_AND, 64'd0, 1'b1, v, rd, un);
        read_direct(1'b0, rd);
        check("R8 and then raise", rd, 64'h9000_0000_0000_0000);

        // R10: alias read returns zero, no pulse; strobe falls the next cycle
        access(1'b0, 1'b0, A_OR, 64'd0, 1'b0, v, rd, un);
        check("R10 alias read valid", {63'd0, v}, 64'd1);
        check("R10 alias read data", rd, 64'd0);
        check("R11 no pulse on alias", {63'd0, un}, 64'd0);
        @(negedge clk);
        check("R10 valid drops", {63'd0, rv_a}, 64'd0);

        // R11: read of an undecoded offset
        access(1'b0, 1'b0, A_BAD, 64'd0, 1'b0, v, rd, un);
        check("R11 undecoded read data", rd, 64'd0);
        check("R11 undecoded read pulse", {63'd0, un}, 64'd1);
        @(negedge clk);
        check("R11 pulse one cycle", {63'd0, un_a}, 64'd0);

        // newer map: R3 R5 R11
        access(1'b1, 1'b1, B_DIR, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, v, rd, un);
        read_direct(1'b1, rd);
        check("R3 newer direct", rd, 64'hFFFF_E000_0000_0000);
        access(1'b1, 1'b1, B_CLR, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, v, rd, un);
        check("R5 clear drops irq", {63'd0, irq_b}, 64'd0);
        read_direct(1'b1, rd);
        check("R5 clear ignores data", rd, 64'd0);
        access(1'b1, 1'b1, B_OR, 64'h8000_0000_0000_0000, 1'b0, v, rd, un);
        check("R5 or sets irq", {63'd0, irq_b}, 64'd1);
        access(1'b1, 1'b1, A_AND, 64'd0, 1'b0, v, rd, un);
        check("R11 legacy alias undecoded on newer", {63'd0, un}, 64'd1);
        read_direct(1'b1, rd);
        check("R11 newer value kept", rd, 64'h8000_0000_0000_0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule